// File: doc/BRIEF.md
# Register-File Datapath with ALU and Local Memory

This block is the execution half of a small processor. It holds four general registers, an arithmetic and logic unit with status flags, and a local word-addressed memory. An external control word, applied one cycle at a time, picks which registers are read, which operation the ALU performs and whether the ALU result or the memory word is written back. It also picks whether memory is written and whether an external constant stands in for the second operand. Nothing inside the block sequences these fields. The controller that drives them decides what each cycle does.

Two combinational read ports, A and B, serve as a shared operand path. The A port feeds the ALU's first input and is also the memory address. The B path is either the register file's B port or the external constant. It feeds the ALU's second input and is also the memory write data. A load is done by addressing memory through A and steering the memory word into the register file. A store is done by addressing through A and writing the B path into memory. Neither operation passes through the ALU. An increment of a memory word therefore takes three cycles: load, add one, store.

Top module: `dp_core`

## Requirements
- R1: An active-low reset clears all four registers to zero, so every read port shows 0 after reset.
- R2: `a_data` shows the register chosen by `a_sel`, and `b_data` shows the register chosen by `b_sel` when `b_const` is 0. Both follow the selects within the same cycle.
- R3: On a rising clock edge with `reg_we` = 1, the register chosen by `d_sel` takes `wb_data`. With `reg_we` = 0, no register changes.
- R4: Arithmetic codes: 5'b00000 passes A, 5'b00001 gives A+1, 5'b00010 gives A+B and 5'b00101 gives A−B, computed as A + ~B + 1. `carry` is the carry out of the top bit, so for subtraction it is 1 when A ≥ B unsigned.
- R5: Logic codes, each with `carry` = `ovf` = 0: 5'b01000 gives A AND B, 5'b01010 gives A OR B, 5'b01100 gives A XOR B and 5'b01110 gives NOT A.
- R6: Shift and pass codes, each with `carry` = `ovf` = 0: 5'b10000 passes B, 5'b10100 shifts B right by one and 5'b11000 shifts B left by one. Both shifts fill with 0.
- R7: `ovf` is 1 on two's-complement overflow of an add, increment or subtract. `neg` equals the top bit of `f_res`, and `zero` is 1 when `f_res` is 0. Any unlisted code gives `f_res` = 0, which makes `zero` = 1.
- R8: The memory holds 2^DW words. It is read combinationally at address `a_data` onto `mem_rdata`. On a rising edge with `mem_we` = 1, the word at `a_data` takes the B path value. With `mem_we` = 0, memory is unchanged.
- R9: `wb_data` is `f_res` when `dst_mem` = 0 and `mem_rdata` when `dst_mem` = 1.
- R10: With `b_const` = 1, `const_in` replaces register B data on the B path. The ALU's B input and the memory write data both see it.
- R11: The three-cycle sequence R3←M[R0], R3←R3+1, M[R0]←R3 leaves the memory word at address R0 one greater, modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| a_sel | input | 2 | A read port register select |
| b_sel | input | 2 | B read port register select |
| d_sel | input | 2 | Write-back register select |
| reg_we | input | 1 | Register write enable |
| fn | input | 5 | ALU function code |
| mem_we | input | 1 | Memory write enable |
| dst_mem | input | 1 | Write-back source: 0 ALU, 1 memory |
| b_const | input | 1 | B path source: 0 register, 1 constant |
| const_in | input | DW | External constant |
| a_data | output | DW | A read port value and memory address |
| b_data | output | DW | B path value after the constant mux |
| f_res | output | DW | ALU result |
| ovf | output | 1 | Signed overflow |
| carry | output | 1 | Carry out |
| neg | output | 1 | Result negative |
| zero | output | 1 | Result zero |
| mem_rdata | output | DW | Memory word at `a_data` |
| wb_data | output | DW | Register write-back value |

## Verification
Register reads, the B path, the ALU result and flags, the memory read and the write-back mux are combinational, so each is due in the same cycle its selects change. The bench drives the control word just after a falling edge and samples these outputs one nanosecond later. Register and memory writes take effect at the next rising edge. Their results are checked only after that edge, at the following falling edge, by reading the written location back through the A port or the memory read path. Each scenario therefore completes its writes before it makes any reads.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam logic [4:0] FN_XFER_A = 5'b00000;
  localparam logic [4:0] FN_INC_A  = 5'b00001;
  localparam logic [4:0] FN_ADD    = 5'b00010;
  localparam logic [4:0] FN_SUB    = 5'b00101;
  localparam logic [4:0] FN_AND    = 5'b01000;
  localparam logic [4:0] FN_OR     = 5'b01010;
  localparam logic [4:0] FN_XOR    = 5'b01100;
  localparam logic [4:0] FN_NOT_A  = 5'b01110;
  localparam logic [4:0] FN_PASS_B = 5'b10000;
  localparam logic [4:0] FN_SHR_B  = 5'b10100;
  localparam logic [4:0] FN_SHL_B  = 5'b11000;

  localparam int unsigned FN_W = 5;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wsel,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   asel,
  input  logic [AW-1:0]   bsel,
  output logic [DW-1:0]   adata,
  output logic [DW-1:0]   bdata,
  output logic [NREG-1:0] ld_vec
);
  logic [DW-1:0] regs [NREG];

  // write-select decoder, gated by the write enable
  for (genvar gi = 0; gi < NREG; gi++) begin : g_dec
    assign ld_vec[gi] = we && (wsel == AW'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ld_vec[i]) regs[i] <= wdata;
      end
    end
  end

  assign adata = regs[asel];
  assign bdata = regs[bsel];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [FN_W-1:0] fn,
  output logic [DW-1:0]   f,
  output logic            v,
  output logic            c,
  output logic            n,
  output logic            z
);
  localparam logic [DW-1:0] ONE = DW'(1);

  function automatic logic [DW:0] add_ext(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic add_ovf(input logic [DW-1:0] x,
                                   input logic [DW-1:0] y,
                                   input logic [DW-1:0] r);
    return (x[DW-1] == y[DW-1]) && (r[DW-1] != x[DW-1]);
  endfunction

  function automatic logic sub_ovf(input logic [DW-1:0] x,
                                   input logic [DW-1:0] y,
                                   input logic [DW-1:0] r);
    return (x[DW-1] != y[DW-1]) && (r[DW-1] != x[DW-1]);
  endfunction

  logic [DW:0] sum;

  always_comb begin
    sum = '0;
    f   = '0;
    c   = 1'b0;
    v   = 1'b0;
    case (fn)
      FN_XFER_A: f = a;
      FN_INC_A: begin
        sum = add_ext(a, ONE, 1'b0);
        f   = sum[DW-1:0];
        c   = sum[DW];
        v   = add_ovf(a, ONE, sum[DW-1:0]);
      end
      FN_ADD: begin
        sum = add_ext(a, b, 1'b0);
        f   = sum[DW-1:0];
        c   = sum[DW];
        v   = add_ovf(a, b, sum[DW-1:0]);
      end
      FN_SUB: begin
        sum = add_ext(a, ~b, 1'b1);
        f   = sum[DW-1:0];
        c   = sum[DW];
        v   = sub_ovf(a, b, sum[DW-1:0]);
      end
      FN_AND:    f = a & b;
      FN_OR:     f = a | b;
      FN_XOR:    f = a ^ b;
      FN_NOT_A:  f = ~a;
      FN_PASS_B: f = b;
      FN_SHR_B:  f = b >> 1;
      FN_SHL_B:  f = b << 1;
      default:   f = '0;
    endcase
  end

  assign n = f[DW-1];
  assign z = (f == '0);
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int unsigned DW   = 8,
  localparam int unsigned DEPTH = 1 << DW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dp_core.sv
module dp_core
  import dp_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   a_sel,
  input  logic [AW-1:0]   b_sel,
  input  logic [AW-1:0]   d_sel,
  input  logic            reg_we,
  input  logic [FN_W-1:0] fn,
  input  logic            mem_we,
  input  logic            dst_mem,
  input  logic            b_const,
  input  logic [DW-1:0]   const_in,
  output logic [DW-1:0]   a_data,
  output logic [DW-1:0]   b_data,
  output logic [DW-1:0]   f_res,
  output logic            ovf,
  output logic            carry,
  output logic            neg,
  output logic            zero,
  output logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   wb_data
);
  logic [DW-1:0]   rf_b;
  logic [NREG-1:0] ld_vec;

  dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .wsel   (d_sel),
    .wdata  (wb_data),
    .asel   (a_sel),
    .bsel   (b_sel),
    .adata  (a_data),
    .bdata  (rf_b),
    .ld_vec (ld_vec)
  );

  // shared B path: register operand or external constant
  assign b_data = b_const ? const_in : rf_b;

  dp_alu #(.DW(DW)) u_alu (
    .a  (a_data),
    .b  (b_data),
    .fn (fn),
    .f  (f_res),
    .v  (ovf),
    .c  (carry),
    .n  (neg),
    .z  (zero)
  );

  dp_ram #(.DW(DW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (a_data),
    .wdata (b_data),
    .rdata (mem_rdata)
  );

  assign wb_data = dst_mem ? mem_rdata : f_res;
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk
  import dp_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   a_sel,
  input logic [AW-1:0]   d_sel,
  input logic            reg_we,
  input logic [FN_W-1:0] fn,
  input logic            mem_we,
  input logic            b_const,
  input logic [DW-1:0]   const_in,
  input logic [DW-1:0]   a_data,
  input logic [DW-1:0]   b_data,
  input logic [DW-1:0]   f_res,
  input logic            ovf,
  input logic [DW-1:0]   mem_rdata,
  input logic [DW-1:0]   wb_data,
  input logic [NREG-1:0] ld_vec
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (a_data == '0));

  // R3
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_vec));

  // R3
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (ld_vec == '0));

  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((a_sel != $past(a_sel)) || (a_data == $past(a_data))));

  // R3
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (d_sel == a_sel)) |=>
      ((a_sel != $past(a_sel)) || (a_data == $past(wb_data))));

  // R8
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ((a_data != $past(a_data)) || (mem_rdata == $past(b_data))));

  // R10
  const_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_const && (fn == FN_PASS_B)) |-> (f_res == const_in));

  // R7
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fn == FN_ADD) && (a_data[DW-1] == b_data[DW-1]) &&
     (f_res[DW-1] != a_data[DW-1])) |-> ovf);
endmodule

bind dp_core dp_core_chk #(.DW(DW), .NREG(NREG)) u_chk (.*);

// File: tb/test_dp_core.sv
`timescale 1ns/1ps
module test_dp_core;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    a_sel = '0, b_sel = '0, d_sel = '0;
  logic          reg_we = 1'b0, mem_we = 1'b0, dst_mem = 1'b0, b_const = 1'b0;
  logic [4:0]    fn = '0;
  logic [DW-1:0] const_in = '0;
  logic [DW-1:0] a_data, b_data, f_res, mem_rdata, wb_data;
  logic          ovf, carry, neg, zero;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  dp_core #(.DW(DW)) i_dp_core (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel), .d_sel(d_sel),
    .reg_we(reg_we), .fn(fn), .mem_we(mem_we), .dst_mem(dst_mem),
    .b_const(b_const), .const_in(const_in), .a_data(a_data), .b_data(b_data),
    .f_res(f_res), .ovf(ovf), .carry(carry), .neg(neg), .zero(zero),
    .mem_rdata(mem_rdata), .wb_data(wb_data)
  );

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    reg_we = 0; mem_we = 0; dst_mem = 0; b_const = 0; fn = 5'b00000;
  endtask

  task automatic load_reg(input int r, input int val);
    idle();
    b_const = 1; const_in = DW'(val); fn = 5'b10000; d_sel = 2'(r); reg_we = 1;
    tick();
    idle();
  endtask

  task automatic read_reg(input int r, output int val);
    a_sel = 2'(r);
    #1 val = int'(a_data);
  endtask

  // bench model: returns {v, c, f}
  function automatic int model(input int code, input int x, input int y);
    int r, cc, vv, sx, sy, s;
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    cc = 0; vv = 0; r = 0;
    case (code)
      0:  r = x;
      1:  begin r = (x + 1) % 256; cc = (x == 255); vv = (x == 127); end
      2:  begin r = (x + y) % 256; cc = (x + y > 255);
                s = sx + sy; vv = (s > 127 || s < -128); end
      5:  begin r = (x - y + 256) % 256; cc = (x >= y);
                s = sx - sy; vv = (s > 127 || s < -128); end
      8:  r = x & y;
      10: r = x | y;
      12: r = x ^ y;
      14: r = 255 - x;
      16: r = y;
      20: r = y / 2;
      24: r = (y * 2) % 256;
      default: r = 0;
    endcase
    return (vv << 9) | (cc << 8) | r;
  endfunction

  task automatic alu_case(input string req, input int code, input int x, input int y);
    int e;
    load_reg(1, x);
    load_reg(2, y);
    a_sel = 2'd1; b_sel = 2'd2; b_const = 0; fn = 5'(code);
    #1;
    e = model(code, x, y);
    check({req, " result"}, int'(f_res), e & 255);
    check({req, " carry"}, int'(carry), (e >> 8) & 1);
    check({req, " ovf R7"}, int'(ovf), (e >> 9) & 1);
    check({req, " neg R7"}, int'(neg), (e >> 7) & 1);
    check({req, " zero R7"}, int'(zero), ((e & 255) == 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    int v;
    for (int r = 0; r < 4; r++) begin
      read_reg(r, v);
      check("R1 reset clear", v, 0);
    end
  endtask

  task automatic t_regfile;
    int v;
    load_reg(1, 8'h35);
    load_reg(2, 8'hCA);
    a_sel = 2'd1; b_sel = 2'd2; b_const = 0;
    #1;
    check("R2 a port", int'(a_data), 8'h35);
    check("R2 b port", int'(b_data), 8'hCA);
    b_sel = 2'd1;
    #1 check("R2 b port follows select", int'(b_data), 8'h35);
    // write attempt with enable low
    b_const = 1; const_in = 8'h77; fn = 5'b10000; d_sel = 2'd1; reg_we = 0;
    tick();
    read_reg(1, v);
    check("R3 no write when disabled", v, 8'h35);
    load_reg(3, 8'h99);
    read_reg(3, v);
    check("R3 write selected reg", v, 8'h99);
    read_reg(2, v);
    check("R3 other reg untouched", v, 8'hCA);
  endtask

  task automatic t_arith;
    alu_case("R4 xfer", 0, 8'h5C, 8'h11);
    alu_case("R4 add", 2, 8'h35, 8'hCA);
    alu_case("R4 add carry wrap", 2, 8'hFF, 8'h01);
    alu_case("R4 add overflow", 2, 8'h7F, 8'h01);
    alu_case("R4 inc", 1, 8'h41, 8'h00);
    alu_case("R4 inc wrap", 1, 8'hFF, 8'h00);
    alu_case("R4 inc overflow", 1, 8'h7F, 8'h00);
    alu_case("R4 sub borrow", 5, 8'h35, 8'hCA);
    alu_case("R4 sub equal", 5, 8'h42, 8'h42);
    alu_case("R4 sub overflow", 5, 8'h80, 8'h01);
  endtask

  task automatic t_logic;
    alu_case("R5 and", 8, 8'hF0, 8'h3C);
    alu_case("R5 or", 10, 8'hF0, 8'h3C);
    alu_case("R5 xor", 12, 8'hF0, 8'h3C);
    alu_case("R5 not", 14, 8'hA5, 8'h00);
  endtask

  task automatic t_shift;
    alu_case("R6 pass b", 16, 8'h12, 8'h81);
    alu_case("R6 shr", 20, 8'h12, 8'h81);
    alu_case("R6 shl", 24, 8'h12, 8'h81);
  endtask

  task automatic t_unused;
    alu_case("R7 unused code 00011", 3, 8'h55, 8'h66);
    alu_case("R7 unused code 11111", 31, 8'h55, 8'h66);
  endtask

  task automatic t_mem;
    int v;
    load_reg(0, 8'h10);
    idle();
    a_sel = 2'd0; b_const = 1; const_in = 8'h5A; mem_we = 1;
    tick();
    idle();
    #1 check("R8 store constant", int'(mem_rdata), 8'h5A);
    b_const = 1; const_in = 8'hEE; mem_we = 0;
    tick();
    #1 check("R8 no store when disabled", int'(mem_rdata), 8'h5A);
    b_const = 0; fn = 5'b00000;
    #1 check("R9 wb from alu", int'(wb_data), 8'h10);
    dst_mem = 1;
    #1 check("R9 wb from memory", int'(wb_data), 8'h5A);
    d_sel = 2'd3; reg_we = 1;
    tick();
    idle();
    read_reg(3, v);
    check("R9 load into register", v, 8'h5A);
  endtask

  task automatic t_const;
    load_reg(1, 8'h20);
    a_sel = 2'd1; b_sel = 2'd1; b_const = 1; const_in = 8'h0F; fn = 5'b00010;
    #1;
    check("R10 b path is constant", int'(b_data), 8'h0F);
    check("R10 alu uses constant", int'(f_res), 8'h2F);
    idle();
  endtask

  task automatic t_seq(input int addr, input int init);
    load_reg(0, addr);
    idle();
    a_sel = 2'd0; b_const = 1; const_in = DW'(init); mem_we = 1;
    tick();
    idle();
    a_sel = 2'd0; dst_mem = 1; d_sel = 2'd3; reg_we = 1;
    tick();
    idle();
    a_sel = 2'd3; fn = 5'b00001; d_sel = 2'd3; reg_we = 1;
    tick();
    idle();
    a_sel = 2'd0; b_sel = 2'd3; b_const = 0; mem_we = 1;
    tick();
    idle();
    a_sel = 2'd0;
    #1 check("R11 memory word incremented", int'(mem_rdata), (init + 1) % 256);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regfile();
    t_arith();
    t_logic();
    t_shift();
    t_unused();
    t_mem();
    t_const();
    t_seq(8'h10, 8'h5A);
    t_seq(8'h22, 8'hFF);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule